// File: doc/BRIEF.md
# Four-Channel Paired Comparator with Recovery Control

This block watches four redundant channels that run in lockstep on identical inputs and are wired as two pairs (channels 0/1 and channels 2/3). In each cycle it first compares the two members of each pair. It then compares across the pairs to find out which channels agree. From that agreement pattern it forwards a trusted result and commands recovery. A channel or two that disagree with an agreeing group are repaired by loading the state of a good channel. A pattern with no usable majority restores every channel to an internally held checkpoint.

Each channel offers a result word with a valid flag and exposes its internal state. The block drives a per-channel correction strobe with the state to load, and a per-channel restore strobe with the checkpoint state to load. It also reports the forwarded result and a verdict code for each compared cycle. Checkpoints are taken from the channels' state only in cycles where all four channels agree, and never more often than a set interval.

Top module: `quad_pair_voter`

## Requirements
- R1: A channel's signature is its valid flag together with its data; the data of a channel whose valid flag is low is ignored. A comparison takes place in a cycle where at least one valid flag is high. All outputs are registered and appear on the next clock edge. After a cycle with no valid flag high, `verdict_vld`, `res_valid`, `fix_en` and `restore_en` are all low.
- R2: After a comparison, `verdict_vld` is 1 and `verdict` holds 1 when all four agree, 2 when exactly three agree, 3 when exactly two agree and the other two differ from them and from each other, 4 for a two-against-two split, and 5 when all four differ.
- R3: When all four agree, the common data is forwarded and no channel is corrected or restored.
- R4: When three agree, the one dissenting channel's bit in `fix_en` is set. `fix_state` carries the state of the lowest-numbered agreeing channel, and the majority data is forwarded.
- R5: When exactly two agree, both dissenting channels are flagged in `fix_en` and receive the state of the lower-numbered agreeing channel. The agreeing data is forwarded.
- R6: A two-against-two split sets all four bits of `restore_en`, drives the stored checkpoint on `restore_state`, forwards no result and corrects nothing.
- R7: When all four signatures differ, the block performs the same full restore as R6.
- R8: `res_valid` is set only when the agreeing group's signature is valid. Otherwise `res_data` is 0, while dissenters are still corrected.
- R9: A cycle counter starts at 0 after reset and counts up by one each clock, holding at `CKPT_PERIOD`-1. When all four channels agree while the counter is at `CKPT_PERIOD`-1, channel 0's state is stored as the checkpoint and the counter returns to 0.
- R10: During reset all outputs are 0, and the checkpoint is loaded with `RESET_STATE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_valid | input | 4 | Valid flag per channel |
| ch_data | input | 4 x DATA_W | Result word per channel |
| ch_state | input | 4 x STATE_W | Internal state exposed by each channel |
| verdict_vld | output | 1 | A comparison was classified |
| verdict | output | 3 | Agreement class code (R2) |
| res_valid | output | 1 | Forwarded result is valid |
| res_data | output | DATA_W | Forwarded majority data |
| fix_en | output | 4 | Per-channel state correction strobe |
| fix_state | output | STATE_W | State to load into corrected channels |
| restore_en | output | 4 | Per-channel rollback strobe |
| restore_state | output | STATE_W | Checkpoint state to load on rollback |

## Verification
The bench builds the block with a 2-bit result word, 4-bit state and a checkpoint interval of 3. Each channel signature then has only eight values: four valid codes and one invalid code carrying four ignored data values. Under these settings, sweeping all 4096 combinations of the four channels reaches every agreement class. It covers every position of a dissenter and every pairing inside or across the two pairs, and mixes valid and invalid channels. Because the interval is short, the checkpoint is taken and later restored many times during the sweep, and a directed run of agreeing cycles followed by splits checks the interval timing exactly.

// File: rtl/qpv_pkg.sv
package qpv_pkg;

    localparam int NCH   = 4;
    localparam int NPAIR = NCH / 2;
    localparam int IDX_W = $clog2(NCH);

    typedef enum logic [2:0] {
        V_IDLE   = 3'd0,
        V_ALL    = 3'd1,
        V_SINGLE = 3'd2,
        V_DOUBLE = 3'd3,
        V_TIE    = 3'd4,
        V_SPLIT  = 3'd5
    } verdict_e;

    typedef struct packed {
        verdict_e         kind;
        logic [NCH-1:0]   dissent;  // channels that must take a good state
        logic [IDX_W-1:0] leader;   // lowest-numbered member of the agreeing group
    } verdict_t;

    function automatic logic [IDX_W-1:0] lowest_set(input logic [NCH-1:0] m);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i]) idx = IDX_W'(i);
        end
        return idx;
    endfunction

    function automatic logic has_majority(input verdict_e k);
        return (k == V_ALL) || (k == V_SINGLE) || (k == V_DOUBLE);
    endfunction

    function automatic logic needs_rollback(input verdict_e k);
        return (k == V_TIE) || (k == V_SPLIT);
    endfunction

endpackage

// File: rtl/qpv_pair_cmp.sv
module qpv_pair_cmp #(
    parameter int SIG_W = 9
) (
    input  logic [SIG_W-1:0] sig_a,
    input  logic [SIG_W-1:0] sig_b,
    output logic             same
);
    // First voting level: agreement inside one pair.
    assign same = (sig_a == sig_b);
endmodule

// File: rtl/qpv_classify.sv
module qpv_classify
    import qpv_pkg::*;
#(
    parameter int SIG_W = 9
) (
    input  logic                      eval,
    input  logic [NCH-1:0][SIG_W-1:0] sig,
    input  logic [NPAIR-1:0]          pair_eq,
    output verdict_t                  verdict
);
    // Second voting level: each member of pair A against each member of pair B.
    logic [1:0][1:0] cross_eq;

    for (genvar a = 0; a < 2; a++) begin : g_side_a
        for (genvar b = 0; b < 2; b++) begin : g_side_b
            assign cross_eq[a][b] = (sig[a] == sig[2 + b]);
        end
    end

    logic [NCH-1:0][1:0] peers;
    logic [NCH-1:0]      with3, with2, with1, with0;

    always_comb begin
        peers[0] = 2'(pair_eq[0]) + 2'(cross_eq[0][0]) + 2'(cross_eq[0][1]);
        peers[1] = 2'(pair_eq[0]) + 2'(cross_eq[1][0]) + 2'(cross_eq[1][1]);
        peers[2] = 2'(pair_eq[1]) + 2'(cross_eq[0][0]) + 2'(cross_eq[1][0]);
        peers[3] = 2'(pair_eq[1]) + 2'(cross_eq[0][1]) + 2'(cross_eq[1][1]);
        for (int i = 0; i < NCH; i++) begin
            with3[i] = (peers[i] == 2'd3);
            with2[i] = (peers[i] == 2'd2);
            with1[i] = (peers[i] == 2'd1);
            with0[i] = (peers[i] == 2'd0);
        end

        verdict.kind    = V_IDLE;
        verdict.dissent = '0;
        verdict.leader  = '0;
        if (eval) begin
            if (|with3) begin
                verdict.kind = V_ALL;
            end else if (|with2) begin
                verdict.kind    = V_SINGLE;
                verdict.dissent = with0;
                verdict.leader  = lowest_set(with2);
            end else if (&with1) begin
                verdict.kind = V_TIE;
            end else if (|with1) begin
                verdict.kind    = V_DOUBLE;
                verdict.dissent = with0;
                verdict.leader  = lowest_set(with1);
            end else begin
                verdict.kind = V_SPLIT;
            end
        end
    end
endmodule

// File: rtl/qpv_ckpt.sv
module qpv_ckpt #(
    parameter int                 STATE_W     = 16,
    parameter int                 PERIOD      = 64,
    parameter logic [STATE_W-1:0] RESET_STATE = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               unanimous,
    input  logic [STATE_W-1:0] state_in,
    output logic [STATE_W-1:0] ckpt
);
    localparam int               CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] since;
    logic             take;

    assign take = unanimous && (since == LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            ckpt  <= RESET_STATE;
        end else if (take) begin
            since <= '0;
            ckpt  <= state_in;
        end else if (since != LIMIT) begin
            since <= since + 1'b1;
        end
    end
endmodule

// File: rtl/quad_pair_voter.sv
module quad_pair_voter
    import qpv_pkg::*;
#(
    parameter int                 DATA_W      = 8,
    parameter int                 STATE_W     = 16,
    parameter int                 CKPT_PERIOD = 64,
    parameter logic [STATE_W-1:0] RESET_STATE = '0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCH-1:0]              ch_valid,
    input  logic [NCH-1:0][DATA_W-1:0]  ch_data,
    input  logic [NCH-1:0][STATE_W-1:0] ch_state,
    output logic                        verdict_vld,
    output logic [2:0]                  verdict,
    output logic                        res_valid,
    output logic [DATA_W-1:0]           res_data,
    output logic [NCH-1:0]              fix_en,
    output logic [STATE_W-1:0]          fix_state,
    output logic [NCH-1:0]              restore_en,
    output logic [STATE_W-1:0]          restore_state
);
    localparam int SIG_W = DATA_W + 1;

    logic [NCH-1:0][SIG_W-1:0] sig;
    logic [NPAIR-1:0]          pair_eq;
    verdict_t                  cls;
    logic [STATE_W-1:0]        ckpt;
    logic                      eval;
    logic                      good_res;
    logic                      roll;

    // Invalid channels contribute an all-zero signature so their data is ignored.
    for (genvar c = 0; c < NCH; c++) begin : g_sig
        assign sig[c] = ch_valid[c] ? {1'b1, ch_data[c]} : '0;
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        qpv_pair_cmp #(.SIG_W(SIG_W)) u_pair (
            .sig_a (sig[2*p]),
            .sig_b (sig[2*p+1]),
            .same  (pair_eq[p])
        );
    end

    assign eval = |ch_valid;

    qpv_classify #(.SIG_W(SIG_W)) u_classify (
        .eval    (eval),
        .sig     (sig),
        .pair_eq (pair_eq),
        .verdict (cls)
    );

    qpv_ckpt #(
        .STATE_W     (STATE_W),
        .PERIOD      (CKPT_PERIOD),
        .RESET_STATE (RESET_STATE)
    ) u_ckpt (
        .clk       (clk),
        .rst       (rst),
        .unanimous (cls.kind == V_ALL),
        .state_in  (ch_state[0]),
        .ckpt      (ckpt)
    );

    assign good_res = has_majority(cls.kind) && sig[cls.leader][DATA_W];
    assign roll     = needs_rollback(cls.kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_vld   <= 1'b0;
            verdict       <= V_IDLE;
            res_valid     <= 1'b0;
            res_data      <= '0;
            fix_en        <= '0;
            fix_state     <= '0;
            restore_en    <= '0;
            restore_state <= '0;
        end else begin
            verdict_vld   <= (cls.kind != V_IDLE);
            verdict       <= cls.kind;
            res_valid     <= good_res;
            res_data      <= good_res ? ch_data[cls.leader] : '0;
            fix_en        <= cls.dissent;
            fix_state     <= (|cls.dissent) ? ch_state[cls.leader] : '0;
            restore_en    <= roll ? '1 : '0;
            restore_state <= roll ? ckpt : '0;
        end
    end
endmodule

// File: rtl/qpv_checker.sv
module qpv_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] ch_valid,
    input logic       verdict_vld,
    input logic [2:0] verdict,
    input logic       res_valid,
    input logic [3:0] fix_en,
    input logic [3:0] restore_en
);
    // R1: a cycle with no valid channel yields a quiet output cycle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (ch_valid == 4'b0) |=> (!verdict_vld && !res_valid && fix_en == 4'b0 && restore_en == 4'b0));

    // R2: only the five defined codes appear with a verdict
    a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
        verdict_vld |-> (verdict >= 3'd1 && verdict <= 3'd5));

    // R3: a forwarded result implies an agreeing group exists
    a_r3_result_needs_group: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (verdict_vld && verdict >= 3'd1 && verdict <= 3'd3));

    // R5: at most two channels are corrected, and only for single or double faults
    a_r5_fix_limited: assert property (@(posedge clk) disable iff (rst)
        (fix_en != 4'b0) |-> ($countones(fix_en) <= 2 && (verdict == 3'd2 || verdict == 3'd3)));

    // R6: rollback covers all four channels or none
    a_r6_rollback_whole: assert property (@(posedge clk) disable iff (rst)
        (restore_en == 4'b0) || (restore_en == 4'hF));

    // R7: rollback only for a tie or total disagreement, never with correction
    a_r7_rollback_cause: assert property (@(posedge clk) disable iff (rst)
        (restore_en != 4'b0) |-> ((verdict == 3'd4 || verdict == 3'd5) && fix_en == 4'b0 && !res_valid));
endmodule

bind quad_pair_voter qpv_checker u_qpv_checker (
    .clk         (clk),
    .rst         (rst),
    .ch_valid    (ch_valid),
    .verdict_vld (verdict_vld),
    .verdict     (verdict),
    .res_valid   (res_valid),
    .fix_en      (fix_en),
    .restore_en  (restore_en)
);

// File: tb/test_quad_pair_voter.sv
`timescale 1ns/1ps
module test_quad_pair_voter;
    localparam int DW  = 2;
    localparam int SW  = 4;
    localparam int PER = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [3:0]          ch_valid = '0;
    logic [3:0][DW-1:0]  ch_data  = '0;
    logic [3:0][SW-1:0]  ch_state = '0;
    logic                verdict_vld;
    logic [2:0]          verdict;
    logic                res_valid;
    logic [DW-1:0]       res_data;
    logic [3:0]          fix_en;
    logic [SW-1:0]       fix_state;
    logic [3:0]          restore_en;
    logic [SW-1:0]       restore_state;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int m_cnt  = 0;          // bench model of the checkpoint interval counter
    int m_ckpt = 0;          // bench model of the stored checkpoint

    always #4 clk = ~clk;

    quad_pair_voter #(.DATA_W(DW), .STATE_W(SW), .CKPT_PERIOD(PER)) i_quad_pair_voter (
        .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_data(ch_data), .ch_state(ch_state),
        .verdict_vld(verdict_vld), .verdict(verdict), .res_valid(res_valid), .res_data(res_data),
        .fix_en(fix_en), .fix_state(fix_state), .restore_en(restore_en), .restore_state(restore_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge, predict, and compare one edge later.
    task automatic step(input logic [3:0] v, input logic [3:0][DW-1:0] d, input logic [3:0][SW-1:0] s);
        int sg[4];
        int pc[4];
        int mx, lead, kind, e_res_v, e_res_d, e_fix, e_fst, e_rst, e_rsv;
        string tag;
        ch_valid = v; ch_data = d; ch_state = s;
        for (int i = 0; i < 4; i++) sg[i] = v[i] ? (4 + int'(d[i])) : 0;
        mx = 0;
        for (int i = 0; i < 4; i++) begin
            pc[i] = 0;
            for (int j = 0; j < 4; j++) if (j != i && sg[j] == sg[i]) pc[i]++;
            if (pc[i] > mx) mx = pc[i];
        end
        lead = 0;
        for (int i = 3; i >= 0; i--) if (pc[i] == mx) lead = i;
        if (v == 4'b0)                                   kind = 0;
        else if (mx == 3)                                kind = 1;
        else if (mx == 2)                                kind = 2;
        else if (mx == 1 && pc[0]+pc[1]+pc[2]+pc[3] == 4) kind = 4;
        else if (mx == 1)                                kind = 3;
        else                                             kind = 5;
        e_fix = 0;
        if (kind == 2 || kind == 3)
            for (int i = 0; i < 4; i++) if (pc[i] < mx) e_fix |= (1 << i);
        e_res_v = (kind >= 1 && kind <= 3 && v[lead]) ? 1 : 0;
        e_res_d = e_res_v ? int'(d[lead]) : 0;
        e_fst   = (e_fix != 0) ? int'(s[lead]) : 0;
        e_rst   = (kind >= 4) ? 15 : 0;
        e_rsv   = (kind >= 4) ? m_ckpt : 0;
        // checkpoint model update for this edge
        if (kind == 1 && m_cnt == PER - 1) begin
            m_ckpt = int'(s[0]);
            m_cnt  = 0;
        end else if (m_cnt != PER - 1) begin
            m_cnt++;
        end
        case (kind)
            0: tag = "R1";
            1: tag = "R3";
            2: tag = "R4";
            3: tag = "R5";
            4: tag = "R6";
            default: tag = "R7";
        endcase
        @(negedge clk);
        chk(verdict_vld == (kind != 0) && int'(verdict) == kind, "R2 verdict",
            int'({verdict_vld, verdict}), ((kind != 0) ? 8 : 0) + kind);
        chk(res_valid == e_res_v[0] && int'(res_data) == e_res_d,
            (kind >= 1 && kind <= 3 && !v[lead]) ? "R8 result" : {tag, " result"},
            int'({res_valid, res_data}), e_res_v * 4 + e_res_d);
        chk(int'(fix_en) == e_fix && int'(fix_state) == e_fst, {tag, " correction"},
            int'({fix_en, fix_state}), e_fix * 16 + e_fst);
        chk(int'(restore_en) == e_rst && int'(restore_state) == e_rsv,
            (kind >= 4) ? "R9 restore checkpoint" : {tag, " restore"},
            int'({restore_en, restore_state}), e_rst * 16 + e_rsv);
    endtask

    initial begin
        logic [3:0]         v;
        logic [3:0][DW-1:0] d;
        logic [3:0][SW-1:0] s;
        repeat (3) @(negedge clk);
        // R10: reset clears every output
        chk(!verdict_vld && verdict == 3'd0 && !res_valid && res_data == '0, "R10 reset status",
            int'({verdict_vld, verdict, res_valid, res_data}), 0);
        chk(fix_en == '0 && fix_state == '0 && restore_en == '0 && restore_state == '0,
            "R10 reset controls", int'({fix_en, fix_state, restore_en, restore_state}), 0);
        rst = 1'b0;
        // Full sweep: each channel takes one of eight codes {valid, data}.
        for (int code = 0; code < 4096; code++) begin
            for (int c = 0; c < 4; c++) begin
                v[c] = code[3*c + 2];
                d[c] = DW'((code >> (3*c)) & 3);
                s[c] = SW'(code + 5*c);
            end
            step(v, d, s);
        end
        // Directed R9 timing: unanimous runs with changing state, then splits reveal the stored checkpoint.
        for (int k = 0; k < 12; k++) begin
            for (int c = 0; c < 4; c++) begin
                v[c] = 1'b1;
                d[c] = DW'(k & 3);
                s[c] = SW'(3*k + c + 1);
            end
            step(v, d, s);
            if (k % 4 == 3) begin
                for (int c = 0; c < 4; c++) d[c] = DW'(c >> 1);   // 0,0,1,1: two-against-two
                step(v, d, s);
                for (int c = 0; c < 4; c++) d[c] = DW'(c);        // all different
                step(v, d, s);
            end
        end
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule